// File: doc/BRIEF.md
# Serial Port FIFO Status and Request Logic

This block sits between a synchronous serial shifter and the bus side of a serial port. It holds a transmit FIFO, which the bus fills and the shifter drains, and a receive FIFO, which the shifter fills and the bus drains. From the occupancy of the two FIFOs and a set of programmable controls it derives the port's status flags, one CPU interrupt line and two DMA request lines.

Each FIFO raises a service flag when it needs attention: the transmit side when it is close to running dry, the receive side when it is close to filling up. A service flag always drives its DMA request line. It drives the CPU interrupt only when the matching enable is set. A word that arrives from the shifter while the receive FIFO is full is thrown away and sets a sticky overrun flag. That flag interrupts the CPU whatever the enables say, never requests DMA, and stays set until software writes a one to it.

Top module: `sport_status`

## Requirements
- R1: `rx_not_empty` is 1 exactly when `rx_count` is nonzero, and it never drives `cpu_irq` by itself.
- R2: `busy` equals `port_en` AND `shifter_active`, so it is 0 whenever the port is disabled.
- R3: `tx_service` and `tx_dma_req` are 1 exactly when `port_en` is 1 and `tx_count` is less than or equal to `tx_thresh` (unsigned 4-bit).
- R4: `rx_service` and `rx_dma_req` are 1 exactly when `port_en` is 1 and `rx_count` is greater than or equal to `rx_thresh` (unsigned 4-bit).
- R5: `cpu_irq` is (`tx_service` AND `tx_irq_en`) OR (`rx_service` AND `rx_irq_en`) OR `overrun`. The enables never change either DMA request.
- R6: With `port_en` at 1, a receive push while `rx_count` is 16 is discarded even if a pop happens in the same cycle. It leaves the FIFO contents unchanged and sets `overrun` at the next edge, and this repeats for every such push.
- R7: A cycle with `ovr_clr_wr`=1 and `ovr_clr_bit`=1 clears `overrun` at the next edge. With `ovr_clr_bit`=0 the write has no effect. If a discard happens in the same cycle as a clearing write, `overrun` stays 1.
- R8: `overrun` never raises `tx_dma_req` or `rx_dma_req`.
- R9: While `port_en` is 0, both FIFOs are emptied at each edge (counts read 0 after it), pushes and pops are ignored, and `overrun` keeps its value.
- R10: A transmit push while `tx_count` is 16 is ignored, even with a same-cycle pop. A pop from an empty FIFO leaves its count unchanged and its read data holding the last value popped.
- R11: Each FIFO returns words in push order. A push or pop updates the count at the next edge, and a popped word appears on the read data port after that edge and holds until the next accepted pop. After reset both counts and both read data ports are 0 and `overrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Port enable; 0 flushes both FIFOs |
| shifter_active | input | 1 | Shifter is sending or receiving a word |
| tx_thresh | input | 4 | Transmit service level |
| rx_thresh | input | 4 | Receive service level |
| tx_irq_en | input | 1 | Lets the transmit service flag reach the CPU interrupt |
| rx_irq_en | input | 1 | Lets the receive service flag reach the CPU interrupt |
| tx_push | input | 1 | Bus writes a word into the transmit FIFO |
| tx_wdata | input | 16 | Word written into the transmit FIFO |
| tx_pop | input | 1 | Shifter takes a word from the transmit FIFO |
| tx_rdata | output | 16 | Last word taken from the transmit FIFO |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_wdata | input | 16 | Received word |
| rx_pop | input | 1 | Bus reads a word from the receive FIFO |
| rx_rdata | output | 16 | Last word read from the receive FIFO |
| ovr_clr_wr | input | 1 | Write strobe to the overrun bit |
| ovr_clr_bit | input | 1 | Data bit written with the strobe; 1 clears |
| tx_count | output | 5 | Transmit FIFO occupancy |
| rx_count | output | 5 | Receive FIFO occupancy |
| rx_not_empty | output | 1 | Receive FIFO holds at least one word |
| busy | output | 1 | Port is enabled and the shifter is active |
| tx_service | output | 1 | Transmit FIFO at or below its level |
| rx_service | output | 1 | Receive FIFO at or above its level |
| overrun | output | 1 | Sticky receive overrun flag |
| cpu_irq | output | 1 | Combined CPU interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
Random traffic runs in three phases. One favours pushes so that both FIFOs sit at 16 and discards occur, one favours pops so that empty pops and stale read data show up, and one is balanced with the thresholds, enables and port enable changing every few cycles. This separates a service compare that is off by one at the threshold from a correct one, and a mask that leaks onto a DMA line from one that does not. Directed sequences then pin down the cases random traffic rarely hits exactly: a clearing write colliding with a discard, a write of zero to the overrun bit, a flush while overrun is set, and thresholds of 0 and 15.

// File: rtl/sport_pkg.sv
package sport_pkg;

  typedef struct packed {
    logic rx_not_empty;
    logic busy;
    logic tx_service;
    logic rx_service;
  } sport_flags_t;

  // Transmit side wants data while its fill is not above the level.
  function automatic logic level_at_or_below(int unsigned fill, int unsigned level);
    return fill <= level;
  endfunction

  // Receive side wants draining once its fill reaches the level.
  function automatic logic level_at_or_above(int unsigned fill, int unsigned level);
    return fill >= level;
  endfunction

  // Sticky bit: a set request dominates a clear in the same cycle.
  function automatic logic sticky_next(logic cur, logic set_req, logic clr_req);
    return set_req | (cur & ~clr_req);
  endfunction

endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       pop,
  output logic [DATA_W-1:0]          rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       drop
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;
  logic [CW-1:0]     count_q;
  logic [DATA_W-1:0] rdata_q;
  logic              empty;
  logic              push_ok;
  logic              pop_ok;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] count_step(logic [CW-1:0] c, logic up, logic dn);
    logic [CW-1:0] r;
    unique case ({up, dn})
      2'b10:   r = c + 1'b1;
      2'b01:   r = c - 1'b1;
      default: r = c;
    endcase
    return r;
  endfunction

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign push_ok = push & ~flush & ~full;
  assign pop_ok  = pop  & ~flush & ~empty;
  assign drop    = push & ~flush & full;

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      rdata_q <= '0;
    end else if (flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) begin
        wr_ptr <= ptr_inc(wr_ptr);
      end
      if (pop_ok) begin
        rdata_q <= mem[rd_ptr];
        rd_ptr  <= ptr_inc(rd_ptr);
      end
      count_q <= count_step(count_q, push_ok, pop_ok);
    end
  end

  assign rdata = rdata_q;
  assign count = count_q;

endmodule

// File: rtl/sport_flags.sv
module sport_flags
  import sport_pkg::*;
#(
  parameter int CW = 5,
  parameter int TW = 4
) (
  input  logic          port_en,
  input  logic          shifter_active,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic [TW-1:0] tx_thresh,
  input  logic [TW-1:0] rx_thresh,
  input  logic          tx_irq_en,
  input  logic          rx_irq_en,
  input  logic          overrun,
  output sport_flags_t  flags,
  output logic          cpu_irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);

  logic tx_low;
  logic rx_high;
  logic tx_irq_part;
  logic rx_irq_part;

  assign tx_low  = port_en & level_at_or_below(32'(tx_count), 32'(tx_thresh));
  assign rx_high = port_en & level_at_or_above(32'(rx_count), 32'(rx_thresh));

  always_comb begin
    flags              = '0;
    flags.rx_not_empty = (rx_count != '0);
    flags.busy         = port_en & shifter_active;
    flags.tx_service   = tx_low;
    flags.rx_service   = rx_high;
  end

  // Enables gate only the CPU path; the DMA lines see the raw flags.
  assign tx_irq_part = tx_low  & tx_irq_en;
  assign rx_irq_part = rx_high & rx_irq_en;
  assign cpu_irq     = tx_irq_part | rx_irq_part | overrun;
  assign tx_dma_req  = tx_low;
  assign rx_dma_req  = rx_high;

endmodule

// File: rtl/sport_overrun.sv
module sport_overrun
  import sport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= sticky_next(flag_q, set_evt, clr_evt);
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/sport_status.sv
module sport_status
  import sport_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int THR_W  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       port_en,
  input  logic                       shifter_active,
  input  logic [THR_W-1:0]           tx_thresh,
  input  logic [THR_W-1:0]           rx_thresh,
  input  logic                       tx_irq_en,
  input  logic                       rx_irq_en,
  input  logic                       tx_push,
  input  logic [DATA_W-1:0]          tx_wdata,
  input  logic                       tx_pop,
  output logic [DATA_W-1:0]          tx_rdata,
  input  logic                       rx_push,
  input  logic [DATA_W-1:0]          rx_wdata,
  input  logic                       rx_pop,
  output logic [DATA_W-1:0]          rx_rdata,
  input  logic                       ovr_clr_wr,
  input  logic                       ovr_clr_bit,
  output logic [$clog2(DEPTH+1)-1:0] tx_count,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic                       rx_not_empty,
  output logic                       busy,
  output logic                       tx_service,
  output logic                       rx_service,
  output logic                       overrun,
  output logic                       cpu_irq,
  output logic                       tx_dma_req,
  output logic                       rx_dma_req
);

  localparam int CW = $clog2(DEPTH + 1);

  // Named internal events, observed by the bound checker.
  logic         flush;
  logic         tx_full;
  logic         rx_full;
  logic         tx_drop_evt;
  logic         rx_drop_evt;
  logic         ovr_clr_evt;
  sport_flags_t flags;

  assign flush       = ~port_en;
  assign ovr_clr_evt = ovr_clr_wr & ovr_clr_bit;

  sport_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (tx_push),
    .wdata (tx_wdata),
    .pop   (tx_pop),
    .rdata (tx_rdata),
    .count (tx_count),
    .full  (tx_full),
    .drop  (tx_drop_evt)
  );

  sport_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (rx_push),
    .wdata (rx_wdata),
    .pop   (rx_pop),
    .rdata (rx_rdata),
    .count (rx_count),
    .full  (rx_full),
    .drop  (rx_drop_evt)
  );

  sport_overrun u_overrun (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (rx_drop_evt),
    .clr_evt (ovr_clr_evt),
    .flag    (overrun)
  );

  sport_flags #(.CW(CW), .TW(THR_W)) u_flags (
    .port_en        (port_en),
    .shifter_active (shifter_active),
    .tx_count       (tx_count),
    .rx_count       (rx_count),
    .tx_thresh      (tx_thresh),
    .rx_thresh      (rx_thresh),
    .tx_irq_en      (tx_irq_en),
    .rx_irq_en      (rx_irq_en),
    .overrun        (overrun),
    .flags          (flags),
    .cpu_irq        (cpu_irq),
    .tx_dma_req     (tx_dma_req),
    .rx_dma_req     (rx_dma_req)
  );

  assign rx_not_empty = flags.rx_not_empty;
  assign busy         = flags.busy;
  assign tx_service   = flags.tx_service;
  assign rx_service   = flags.rx_service;

endmodule

// File: rtl/sport_status_chk.sv
module sport_status_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int THR_W  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       port_en,
  input logic                       shifter_active,
  input logic [THR_W-1:0]           tx_thresh,
  input logic [THR_W-1:0]           rx_thresh,
  input logic                       tx_irq_en,
  input logic                       rx_irq_en,
  input logic                       tx_pop,
  input logic                       rx_push,
  input logic                       rx_pop,
  input logic [DATA_W-1:0]          rx_rdata,
  input logic                       ovr_clr_wr,
  input logic                       ovr_clr_bit,
  input logic [$clog2(DEPTH+1)-1:0] tx_count,
  input logic [$clog2(DEPTH+1)-1:0] rx_count,
  input logic                       rx_not_empty,
  input logic                       busy,
  input logic                       tx_service,
  input logic                       rx_service,
  input logic                       overrun,
  input logic                       cpu_irq,
  input logic                       tx_dma_req,
  input logic                       rx_dma_req,
  input logic                       tx_drop_evt,
  input logic                       rx_drop_evt
);

  localparam int CW = $clog2(DEPTH + 1);

  a_r1_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rx_not_empty == (rx_count != '0));

  a_r2_busy_gated: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (port_en && shifter_active));

  a_r3_tx_level: assert property (@(posedge clk) disable iff (!rst_n)
    tx_service |-> (port_en && tx_count <= CW'(tx_thresh)));

  a_r4_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
    rx_service |-> (port_en && rx_count >= CW'(rx_thresh)));

  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_irq_en && !rx_irq_en && !overrun) |-> !cpu_irq);

  a_r6_drop_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop_evt |=> overrun);

  a_r6_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop_evt && !rx_pop) |=> (rx_count == CW'(DEPTH)));

  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr_wr && ovr_clr_bit && !rx_drop_evt) |=> !overrun);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !(ovr_clr_wr && ovr_clr_bit)) |=> overrun);

  a_r8_no_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !tx_service && !rx_service) |-> (!tx_dma_req && !rx_dma_req));

  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (tx_count == '0 && rx_count == '0));

  a_r10_tx_full: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_drop_evt && !tx_pop) |=> (tx_count == CW'(DEPTH)));

  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && rx_pop && !rx_push && rx_count == '0) |=> (rx_count == '0 && $stable(rx_rdata)));

endmodule

bind sport_status sport_status_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .THR_W  (THR_W)
) u_sport_status_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .port_en        (port_en),
  .shifter_active (shifter_active),
  .tx_thresh      (tx_thresh),
  .rx_thresh      (rx_thresh),
  .tx_irq_en      (tx_irq_en),
  .rx_irq_en      (rx_irq_en),
  .tx_pop         (tx_pop),
  .rx_push        (rx_push),
  .rx_pop         (rx_pop),
  .rx_rdata       (rx_rdata),
  .ovr_clr_wr     (ovr_clr_wr),
  .ovr_clr_bit    (ovr_clr_bit),
  .tx_count       (tx_count),
  .rx_count       (rx_count),
  .rx_not_empty   (rx_not_empty),
  .busy           (busy),
  .tx_service     (tx_service),
  .rx_service     (rx_service),
  .overrun        (overrun),
  .cpu_irq        (cpu_irq),
  .tx_dma_req     (tx_dma_req),
  .rx_dma_req     (rx_dma_req),
  .tx_drop_evt    (tx_drop_evt),
  .rx_drop_evt    (rx_drop_evt)
);

// File: tb/test_sport_status.sv
`timescale 1ns/1ps
module test_sport_status;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b0;
  logic        shifter_active = 1'b0;
  logic [3:0]  tx_thresh = 4'd0;
  logic [3:0]  rx_thresh = 4'd0;
  logic        tx_irq_en = 1'b0;
  logic        rx_irq_en = 1'b0;
  logic        tx_push = 1'b0;
  logic [15:0] tx_wdata = '0;
  logic        tx_pop = 1'b0;
  logic [15:0] tx_rdata;
  logic        rx_push = 1'b0;
  logic [15:0] rx_wdata = '0;
  logic        rx_pop = 1'b0;
  logic [15:0] rx_rdata;
  logic        ovr_clr_wr = 1'b0;
  logic        ovr_clr_bit = 1'b0;
  logic [4:0]  tx_count;
  logic [4:0]  rx_count;
  logic        rx_not_empty, busy, tx_service, rx_service, overrun;
  logic        cpu_irq, tx_dma_req, rx_dma_req;

  always #2.5 clk = ~clk;

  sport_status i_sport_status (.*);

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference state
  logic [15:0] q_tx[$];
  logic [15:0] q_rx[$];
  logic [15:0] m_tx_rd = '0;
  logic [15:0] m_rx_rd = '0;
  logic        m_ovr = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit want_tx(bit en, int fill, int lvl);
    if (!en) return 1'b0;
    return !(fill > lvl);
  endfunction

  function automatic bit want_rx(bit en, int fill, int lvl);
    if (!en) return 1'b0;
    return !(fill < lvl);
  endfunction

  // Apply one edge of the reference using the inputs now being driven.
  task automatic model_step();
    int tx_n = q_tx.size();
    int rx_n = q_rx.size();
    bit drop = port_en && rx_push && (rx_n == DEPTH);
    if (drop) m_ovr = 1'b1;
    else if (ovr_clr_wr && ovr_clr_bit) m_ovr = 1'b0;
    if (!port_en) begin
      q_tx.delete();
      q_rx.delete();
    end else begin
      if (tx_pop && tx_n > 0) m_tx_rd = q_tx.pop_front();
      if (tx_push && tx_n < DEPTH) q_tx.push_back(tx_wdata);
      if (rx_pop && rx_n > 0) m_rx_rd = q_rx.pop_front();
      if (rx_push && rx_n < DEPTH) q_rx.push_back(rx_wdata);
    end
  endtask

  task automatic compare_all();
    bit et = want_tx(port_en, q_tx.size(), int'(tx_thresh));
    bit er = want_rx(port_en, q_rx.size(), int'(rx_thresh));
    bit ei = (et && tx_irq_en) || (er && rx_irq_en) || m_ovr;
    chk(tx_count == 5'(q_tx.size()), "R11 tx_count", tx_count, q_tx.size());
    chk(rx_count == 5'(q_rx.size()), "R11 rx_count", rx_count, q_rx.size());
    chk(tx_rdata == m_tx_rd, "R11 tx_rdata", tx_rdata, m_tx_rd);
    chk(rx_rdata == m_rx_rd, "R11 rx_rdata", rx_rdata, m_rx_rd);
    chk(rx_not_empty == (q_rx.size() > 0), "R1 rx_not_empty", rx_not_empty, q_rx.size() > 0);
    chk(busy == (port_en && shifter_active), "R2 busy", busy, port_en && shifter_active);
    chk(tx_service == et && tx_dma_req == et, "R3 tx service/dma", {tx_service, tx_dma_req}, {et, et});
    chk(rx_service == er && rx_dma_req == er, "R4 rx service/dma", {rx_service, rx_dma_req}, {er, er});
    chk(cpu_irq == ei, "R5 cpu_irq", cpu_irq, ei);
    chk(overrun == m_ovr, "R6 overrun", overrun, m_ovr);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic idle_inputs();
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    ovr_clr_wr = 0; ovr_clr_bit = 0;
  endtask

  task automatic random_phase(int n, int p_push, int p_pop);
    for (int i = 0; i < n; i++) begin
      tx_push     = ($urandom_range(99) < p_push);
      rx_push     = ($urandom_range(99) < p_push);
      tx_pop      = ($urandom_range(99) < p_pop);
      rx_pop      = ($urandom_range(99) < p_pop);
      tx_wdata    = 16'($urandom);
      rx_wdata    = 16'($urandom);
      ovr_clr_wr  = ($urandom_range(99) < 8);
      ovr_clr_bit = 1'($urandom);
      shifter_active = 1'($urandom);
      if ($urandom_range(99) < 10) begin
        tx_thresh = 4'($urandom);
        rx_thresh = 4'($urandom);
        tx_irq_en = 1'($urandom);
        rx_irq_en = 1'($urandom);
      end
      port_en = ($urandom_range(99) < 97);
      tick();
    end
    idle_inputs();
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(tx_count == 0 && rx_count == 0, "R11 reset counts", {tx_count, rx_count}, 0);
    chk(overrun == 0 && cpu_irq == 0, "R11 reset overrun/irq", {overrun, cpu_irq}, 0);
    chk(tx_rdata == 0 && rx_rdata == 0, "R11 reset rdata", {tx_rdata, rx_rdata}, 0);
    rst_n = 1'b1;
    port_en = 1'b1;
    tick();

    // R1/R3/R4 thresholds 0 and 15 on empty FIFOs
    tx_thresh = 4'd0; rx_thresh = 4'd0; tx_irq_en = 0; rx_irq_en = 0;
    tick();
    chk(rx_service && rx_dma_req && !cpu_irq, "R5 masked rx still requests DMA", {rx_service, rx_dma_req, cpu_irq}, 6);
    // Fill rx to 16 and push three more: R6
    rx_thresh = 4'd15; tx_thresh = 4'd15;
    for (int i = 0; i < DEPTH; i++) begin
      rx_push = 1; rx_wdata = 16'(16'hA000 + i);
      tx_push = 1; tx_wdata = 16'(16'hB000 + i);
      tick();
    end
    chk(!tx_service, "R3 tx count 16 above level 15", tx_service, 0);
    tx_wdata = 16'hDEAD;
    rx_wdata = 16'hBEEF;
    tick(); tick();
    chk(tx_count == 16, "R10 tx push on full ignored", tx_count, 16);
    chk(overrun && cpu_irq && !tx_dma_req, "R8 overrun irq without tx DMA", {overrun, cpu_irq, tx_dma_req}, 6);
    // R7: clear colliding with a discard keeps overrun
    ovr_clr_wr = 1; ovr_clr_bit = 1;
    tick();
    chk(overrun == 1, "R7 set wins over clear", overrun, 1);
    idle_inputs();
    // R7: write of zero has no effect
    ovr_clr_wr = 1; ovr_clr_bit = 0;
    tick();
    chk(overrun == 1, "R7 zero write keeps flag", overrun, 1);
    ovr_clr_bit = 1;
    tick();
    chk(overrun == 0, "R7 one write clears", overrun, 0);
    idle_inputs();
    // R6: drain receive FIFO, data must be the first 16 words
    for (int i = 0; i < DEPTH; i++) begin
      rx_pop = 1;
      tick();
      chk(rx_rdata == 16'(16'hA000 + i), "R6 kept words in order", rx_rdata, 16'hA000 + i);
    end
    // R10: pop when empty keeps last value
    tick(); tick();
    chk(rx_rdata == 16'hA00F && rx_count == 0, "R10 empty pop holds", rx_rdata, 16'hA00F);
    idle_inputs();
    // R9: flush with overrun set keeps overrun
    for (int i = 0; i < DEPTH + 1; i++) begin
      rx_push = 1; rx_wdata = 16'(i);
      tick();
    end
    idle_inputs();
    port_en = 0;
    tick();
    chk(tx_count == 0 && rx_count == 0 && overrun, "R9 flush keeps overrun", {tx_count, rx_count, overrun}, 1);
    chk(!busy && !tx_service && !rx_service, "R9 disabled flags low", {busy, tx_service, rx_service}, 0);
    port_en = 1;
    ovr_clr_wr = 1; ovr_clr_bit = 1;
    tick();
    idle_inputs();

    random_phase(800, 75, 30);
    random_phase(800, 30, 75);
    random_phase(1500, 50, 50);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule